// File: doc/BRIEF.md
# Multi-cycle Accumulator Processor Core

This block is a small processor built around one 16-bit accumulator. Each instruction is a 16-bit word. The top four bits select the operation and the low twelve bits name a word in a 4096-word memory. The core fetches and executes one instruction at a time. Every instruction is cut into register transfers, and a step counter t1..t6 sequences them. Each special register loads through its own source selector. That selector is driven by control terms of the form "decoded opcode AND step strobe".

The memory sits outside the core and is synchronous: a word appears on the read-data port one clock after its address is presented. To meet that latency, the core drives the address port with the value that the address register is loading in the current cycle. The read data is therefore ready when the data register captures it on the following step. The core also has a 16-bit input port that it samples into an input register, a 16-bit output register, and a halt flag.

Top module: `acc_cpu_core`

## Requirements
- R1: An instruction word carries the opcode in bits 15:12 and a direct word address in bits 11:0. The opcodes are: 0 add, 1 and, 2 clear AC, 3 rotate AC left, 4 complement AC, 5 jump, 6 jump-if-zero, 7 load, 8 store, 9 input, 10 output, 11 halt. Codes 12 to 15 change nothing except the program counter.
- R2: A synchronous active-high reset clears every register, including the halt flag. After reset the core starts at step t1 with PC = 0, so the first fetch address is 0, `out_data` is 0, `halted` is 0 and `mem_we` is 0.
- R3: The fetch is the same for every opcode. In t1 the address register takes PC and the read is issued. In t2 the data register takes the memory word and PC increments, wrapping from 4095 to 0. In t3 the opcode register takes data bits 15:12.
- R4: Add leaves (AC + M[a]) mod 2^16 in AC. And leaves the bitwise AND of AC and M[a] in AC.
- R5: Load copies M[a] into AC. Store writes AC to M[a] with exactly one `mem_we` pulse in t6, with `mem_wdata` equal to AC, and it leaves AC unchanged.
- R6: Clear sets AC to 0. Complement inverts every AC bit. Rotate moves every bit up by one place, and bit 15 moves into bit 0.
- R7: Jump loads PC from the address field. Jump-if-zero does the same only when AC is 0; otherwise execution continues with the next word.
- R8: Input copies the sampled input port into AC. Output copies AC to `out_data`, which holds that value until the next output instruction.
- R9: Halt sets `halted`. While `halted` is set, the step counter and every register hold their values, no memory write occurs, and a change on `in_data` has no effect.
- R10: Add, and, load and store take 6 clocks each. Every other opcode, including 12 to 15, takes 4 clocks. The next fetch follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address presented to the memory this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data (the data register) |
| mem_rdata | input | 16 | Memory read data, valid one clock after its address |
| in_data | input | 16 | Input port, sampled into the input register |
| out_data | output | 16 | Output register |
| halted | output | 1 | Halt flag |

## Verification
Each arithmetic and logic opcode runs inside the same load-op-output-halt program. The operand pairs are chosen so that a wrong result cannot hide:
- An add that carries out of bit 15 separates modular wrap from saturation or a lost carry.
- A rotate of 0x8001 tells a rotate from a plain shift.
- An inert opcode shows up as an unchanged AC.

The clocks counted until halt separate 6-step instructions from 4-step ones. Jump-if-zero runs twice, with AC zero and with AC non-zero, to pin down the branch condition. A program that jumps to the last address and then falls through shows the PC wrapping to 0. A store program, and an idle stretch after halt, confirm the single write pulse and the frozen state.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_AND = 4'd1, OP_CLR = 4'd2, OP_ROL = 4'd3,
    OP_INV = 4'd4, OP_JMP = 4'd5, OP_JZ  = 4'd6, OP_LD  = 4'd7,
    OP_ST  = 4'd8, OP_IN  = 4'd9, OP_OUT = 4'd10, OP_HALT = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    AC_KEEP, AC_SUM, AC_CONJ, AC_NEG, AC_ROT, AC_MEM, AC_PORT, AC_ZERO
  } ac_src_e;

  typedef struct packed {
    logic    mar_pc;
    logic    mar_ir;
    logic    mdr_mem;
    logic    mdr_ac;
    logic    pc_inc;
    logic    pc_ir;
    logic    opc_ld;
    logic    outr_ld;
    logic    hlt_set;
    logic    wr;
    logic    last;
    ac_src_e ac_src;
  } ctl_t;

  function automatic logic uses_operand(input logic [3:0] code);
    return code == OP_ADD || code == OP_AND || code == OP_LD || code == OP_ST;
  endfunction

endpackage

// File: rtl/acc_cpu_microseq.sv
module acc_cpu_microseq #(
  parameter int NSTEP = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             last,
  output logic [NSTEP-1:0] strobe
);
  localparam int SW = $clog2(NSTEP);

  logic [SW-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (!hold) begin
      if (last || step == SW'(NSTEP - 1)) step <= '0;
      else                                step <= step + 1'b1;
    end
  end

  for (genvar i = 0; i < NSTEP; i++) begin : g_strobe
    assign strobe[i] = (step == SW'(i));
  end

  // an instruction that ends hands control back to the fetch step
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (!hold && last) |=> strobe[0]);

  // a frozen core keeps its step
  assert_step_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(strobe));

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int NSTEP = 6,
  parameter int OPC_W = 4
) (
  input  logic [NSTEP-1:0] strobe,
  input  logic [OPC_W-1:0] opc,
  input  logic             ac_zero,
  input  logic             halted,
  output ctl_t             ctl
);
  logic is_mem;

  assign is_mem = uses_operand(opc);

  always_comb begin
    ctl = '0;
    if (!halted) begin
      // fetch, shared by every opcode
      if (strobe[0]) ctl.mar_pc = 1'b1;
      if (strobe[1]) begin
        ctl.mdr_mem = 1'b1;
        ctl.pc_inc  = 1'b1;
      end
      if (strobe[2]) ctl.opc_ld = 1'b1;
      // execute, first step
      if (strobe[3]) begin
        if (is_mem) begin
          ctl.mar_ir = 1'b1;
        end else begin
          ctl.last = 1'b1;
          case (opc)
            OP_CLR:  ctl.ac_src  = AC_ZERO;
            OP_ROL:  ctl.ac_src  = AC_ROT;
            OP_INV:  ctl.ac_src  = AC_NEG;
            OP_JMP:  ctl.pc_ir   = 1'b1;
            OP_JZ:   ctl.pc_ir   = ac_zero;
            OP_IN:   ctl.ac_src  = AC_PORT;
            OP_OUT:  ctl.outr_ld = 1'b1;
            OP_HALT: ctl.hlt_set = 1'b1;
            default: ;
          endcase
        end
      end
      // operand access
      if (strobe[4] && is_mem) begin
        if (opc == OP_ST) ctl.mdr_ac  = 1'b1;
        else              ctl.mdr_mem = 1'b1;
      end
      if (strobe[5]) begin
        ctl.last = 1'b1;
        case (opc)
          OP_ADD:  ctl.ac_src = AC_SUM;
          OP_AND:  ctl.ac_src = AC_CONJ;
          OP_LD:   ctl.ac_src = AC_MEM;
          OP_ST:   ctl.wr     = 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] conj,
  output logic [DATA_W-1:0] neg,
  output logic [DATA_W-1:0] rot
);
  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] x, y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] f_and(input logic [DATA_W-1:0] x, y);
    return x & y;
  endfunction

  function automatic logic [DATA_W-1:0] f_not(input logic [DATA_W-1:0] x);
    return ~x;
  endfunction

  function automatic logic [DATA_W-1:0] f_rotl(input logic [DATA_W-1:0] x);
    return {x[DATA_W-2:0], x[DATA_W-1]};
  endfunction

  assign sum  = f_add(a, b);
  assign conj = f_and(a, b);
  assign neg  = f_not(a);
  assign rot  = f_rotl(a);

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 4,
  parameter int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data,
  output logic              halted
);
  localparam int NSTEP = 6;

  logic [DATA_W-1:0] ac, mdr, inr, outr, ac_next;
  logic [ADDR_W-1:0] pc, mar;
  logic [OPC_W-1:0]  opc;
  logic              hlt, ac_zero;
  logic [NSTEP-1:0]  strobe;
  logic [DATA_W-1:0] alu_sum, alu_conj, alu_neg, alu_rot;
  ctl_t              ctl;

  assign ac_zero = (ac == '0);

  acc_cpu_microseq #(.NSTEP(NSTEP)) u_seq (
    .clk(clk), .rst(rst), .hold(hlt), .last(ctl.last), .strobe(strobe)
  );

  acc_cpu_ctrl #(.NSTEP(NSTEP), .OPC_W(OPC_W)) u_ctrl (
    .strobe(strobe), .opc(opc), .ac_zero(ac_zero), .halted(hlt), .ctl(ctl)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .a(ac), .b(mdr), .sum(alu_sum), .conj(alu_conj), .neg(alu_neg), .rot(alu_rot)
  );

  // seven-way source selector for the accumulator
  always_comb begin
    case (ctl.ac_src)
      AC_SUM:  ac_next = alu_sum;
      AC_CONJ: ac_next = alu_conj;
      AC_NEG:  ac_next = alu_neg;
      AC_ROT:  ac_next = alu_rot;
      AC_MEM:  ac_next = mdr;
      AC_PORT: ac_next = inr;
      AC_ZERO: ac_next = '0;
      default: ac_next = ac;
    endcase
  end

  // the address the register is loading now, so a synchronous memory is ready next step
  always_comb begin
    if (ctl.mar_pc)      mem_addr = pc;
    else if (ctl.mar_ir) mem_addr = mdr[ADDR_W-1:0];
    else                 mem_addr = mar;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac   <= '0;
      pc   <= '0;
      opc  <= '0;
      mar  <= '0;
      mdr  <= '0;
      inr  <= '0;
      outr <= '0;
      hlt  <= 1'b0;
    end else if (!hlt) begin
      inr <= in_data;
      ac  <= ac_next;
      if (ctl.mar_pc)      mar <= pc;
      else if (ctl.mar_ir) mar <= mdr[ADDR_W-1:0];
      if (ctl.mdr_mem)     mdr <= mem_rdata;
      else if (ctl.mdr_ac) mdr <= ac;
      if (ctl.pc_ir)       pc  <= mdr[ADDR_W-1:0];
      else if (ctl.pc_inc) pc  <= pc + 1'b1;
      if (ctl.opc_ld)      opc <= mdr[DATA_W-1 -: OPC_W];
      if (ctl.outr_ld)     outr <= ac;
      if (ctl.hlt_set)     hlt  <= 1'b1;
    end
  end

  assign mem_we    = ctl.wr;
  assign mem_wdata = mdr;
  assign out_data  = outr;
  assign halted    = hlt;

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    strobe[1] && !hlt |=> pc == $past(pc) + 1'b1);

  assert_opc_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    strobe[2] && !hlt |=> opc == $past(mdr[DATA_W-1 -: OPC_W]));

  assert_store_data_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == ac && strobe[5]);

  assert_jz_skip_R7: assert property (@(posedge clk) disable iff (rst)
    strobe[3] && !hlt && opc == OP_JZ && !ac_zero |=> pc == $past(pc));

  assert_jz_take_R7: assert property (@(posedge clk) disable iff (rst)
    strobe[3] && !hlt && opc == OP_JZ && ac_zero |=> pc == $past(mdr[ADDR_W-1:0]));

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    hlt |=> hlt && $stable(pc) && $stable(ac) && $stable(outr) && !mem_we);

endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [15:0] in_data = 16'h0;
  logic [15:0] out_data;
  logic        halted;

  int total = 0;
  int bad = 0;
  int wr_count = 0;
  bit finished = 0;

  // bench memory: 256 words, mirrored through the 12-bit address space
  logic [15:0] mem [256];

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
    if (!rst && mem_we) wr_count <= wr_count + 1;
  end

  acc_cpu_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_data(in_data),
    .out_data(out_data), .halted(halted)
  );

  // {opcode, a, b}: program is LD a; <op> b; OUT; HALT
  localparam int NV = 9;
  localparam logic [35:0] VEC [NV] = '{
    {4'd0,  16'hFFFF, 16'h0001},
    {4'd0,  16'h1234, 16'h4321},
    {4'd1,  16'hF0F0, 16'h3C3C},
    {4'd2,  16'hBEEF, 16'h0000},
    {4'd3,  16'h8001, 16'h0000},
    {4'd4,  16'h00FF, 16'h0000},
    {4'd7,  16'h1111, 16'h2222},
    {4'd12, 16'h5A5A, 16'h0F0F},
    {4'd15, 16'hC3C3, 16'h0F0F}
  };

  function automatic logic [15:0] model(input logic [3:0] op, input logic [15:0] a, b);
    case (op)
      4'd0: return 16'((32'(a) + 32'(b)) % 32'h10000);
      4'd1: return a & b;
      4'd2: return 16'h0;
      4'd3: return {a[14:0], a[15]};
      4'd4: return a ^ 16'hFFFF;
      4'd7: return b;
      default: return a;
    endcase
  endfunction

  function automatic int steps(input logic [3:0] op);
    return (op == 4'd0 || op == 4'd1 || op == 4'd7 || op == 4'd8) ? 6 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  endtask

  task automatic reset_core;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(output int n);
    n = 0;
    while (!halted && n < 1000) begin
      @(posedge clk);
      #1;
      n++;
    end
  endtask

  initial begin
    int n;
    logic [15:0] r, held;
    logic [11:0] held_addr;
    int wr_before;

    // R2: reset state, sampled while reset is held and at the first step
    clear_mem();
    @(negedge clk);
    repeat (2) @(negedge clk);
    check(out_data == 16'h0, "R2 out_data", 32'(out_data), 32'h0);
    check(halted == 1'b0, "R2 halted", 32'(halted), 32'h0);
    check(mem_we == 1'b0, "R2 mem_we", 32'(mem_we), 32'h0);
    check(mem_addr == 12'h0, "R2/R3 first fetch address", 32'(mem_addr), 32'h0);

    // table: R1, R4, R6, R5 (load), R10 timing
    for (int v = 0; v < NV; v++) begin
      logic [3:0]  op;
      logic [15:0] a, b;
      op = VEC[v][35:32];
      a  = VEC[v][31:16];
      b  = VEC[v][15:0];
      clear_mem();
      mem[0] = 16'h7020;
      mem[1] = {op, 12'h021};
      mem[2] = 16'hA000;
      mem[3] = 16'hB000;
      mem[8'h20] = a;
      mem[8'h21] = b;
      reset_core();
      run(n);
      r = model(op, a, b);
      check(out_data == r, $sformatf("R1/R4/R6 op=%0d result", op), 32'(out_data), 32'(r));
      check(n == 14 + steps(op), $sformatf("R10 op=%0d clocks", op), 32'(n), 32'(14 + steps(op)));
    end

    // R5: store then output
    clear_mem();
    mem[0] = 16'h7020; mem[1] = 16'h8030; mem[2] = 16'hA000; mem[3] = 16'hB000;
    mem[8'h20] = 16'h4D2B;
    reset_core();
    wr_before = wr_count;
    run(n);
    check(mem[8'h30] == 16'h4D2B, "R5 stored word", 32'(mem[8'h30]), 32'h4D2B);
    check(wr_count - wr_before == 1, "R5 write pulses", 32'(wr_count - wr_before), 32'd1);
    check(out_data == 16'h4D2B, "R5 AC kept after store", 32'(out_data), 32'h4D2B);

    // R7: jump-if-zero, taken and not taken
    for (int k = 0; k < 2; k++) begin
      clear_mem();
      mem[0] = 16'h7020; mem[1] = 16'h6004; mem[2] = 16'hA000; mem[3] = 16'hB000;
      mem[4] = 16'h4000; mem[5] = 16'hA000; mem[6] = 16'hB000;
      mem[8'h20] = (k == 0) ? 16'h0000 : 16'h0007;
      reset_core();
      run(n);
      r = (k == 0) ? 16'hFFFF : 16'h0007;
      check(out_data == r, "R7 jump-if-zero", 32'(out_data), 32'(r));
    end

    // R7: unconditional jump
    clear_mem();
    mem[0] = 16'h5003; mem[1] = 16'hA000; mem[2] = 16'hB000;
    mem[3] = 16'h4000; mem[4] = 16'hA000; mem[5] = 16'hB000;
    reset_core();
    run(n);
    check(out_data == 16'hFFFF, "R7 jump", 32'(out_data), 32'hFFFF);

    // R3: PC wraps from the last address to 0
    clear_mem();
    mem[0] = 16'h6FFF; mem[8'hFF] = 16'h4000; mem[1] = 16'hA000; mem[2] = 16'hB000;
    reset_core();
    run(n);
    check(out_data == 16'hFFFF, "R3 PC wrap", 32'(out_data), 32'hFFFF);

    // R8: input then output
    clear_mem();
    mem[0] = 16'h9000; mem[1] = 16'hA000; mem[2] = 16'hB000;
    in_data = 16'hA5C3;
    reset_core();
    run(n);
    check(out_data == 16'hA5C3, "R8 input to output", 32'(out_data), 32'hA5C3);

    // R9: frozen after halt, input changes ignored
    held = out_data;
    held_addr = mem_addr;
    wr_before = wr_count;
    in_data = 16'h1234;
    repeat (20) @(negedge clk);
    check(halted == 1'b1, "R9 halted stays", 32'(halted), 32'h1);
    check(out_data == held, "R9 output frozen", 32'(out_data), 32'(held));
    check(mem_addr == held_addr && wr_count == wr_before, "R9 no memory activity",
          32'(mem_addr), 32'(held_addr));

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule